// File: doc/BRIEF.md
# Serial Register Target with Stuck-Clock Release

This block is a two-wire serial bus target that lets a bus controller reach a sixteen-entry byte register file. It runs on a fast system clock and watches oversampled copies of the serial clock (SCL) and serial data (SDA) lines. From these it finds START, STOP and clock edges, matches the 7-bit device address, and then acts as a write sink or a read source. It pulls SDA low only through an open-drain enable.

The register storage lives outside the block. The block exposes a simple port for it: a pointer-valued address, a write strobe with data, and a read-fetch strobe with combinational return data. The address pointer is loaded by the first byte of a write transfer. It steps after every register byte moved in either direction and wraps from the last entry to the first. A counter watches for SCL stuck low. When the counter expires, the interface returns to idle and lets go of SDA, provided the timekeeping oscillator enable is high.

Top module: `i2cr_target`

## Requirements
- R1: After reset, sda_oe, reg_we and reg_rd are all low.
- R2: A first byte after START of 0xD0 (device address 0x68 in bits 7:1, bit 0 = 0 for write) or 0xD1 (bit 0 = 1 for read) is acknowledged by driving SDA low during the ninth clock.
- R3: A first byte with any other address gets no acknowledge. The block then never drives SDA and makes no register access until the next START.
- R4: In a write transfer, the first data byte is acknowledged and its low four bits load the pointer. Its upper bits are ignored, and it causes no register write.
- R5: Every later write byte is acknowledged. It produces one reg_we pulse with reg_addr equal to the pointer and reg_wdata equal to the byte, and the pointer then steps by one.
- R6: The pointer wraps from 0xF to 0x0, in write bursts and in read bursts.
- R7: A read transfer sends the entry at the current pointer, MSB first, and steps the pointer after each byte. A controller NACK ends the read, and SDA stays released until the next START.
- R8: A repeated START is accepted in any state, and the following address byte is decoded afresh.
- R9: A STOP returns the block to idle with SDA released. A write byte cut short by a STOP is not written.
- R10: With osc_en high, SCL held low for TIMEOUT_CYC system cycles returns the block to idle and releases SDA. A fresh START is then served normally.
- R11: With osc_en low, the timeout counter holds its value, so SDA stays driven for as long as SCL is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| osc_en | input | 1 | Timekeeping oscillator running; gates the stuck-clock timeout |
| sda_oe | output | 1 | When high, SDA is pulled low |
| reg_addr | output | REG_AW | Register pointer presented to the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Write data for reg_we |
| reg_rd | output | 1 | One-cycle pulse when a byte is fetched from reg_rdata |
| reg_rdata | input | 8 | Register file content at reg_addr |

## Verification
The embedded assertions check the following every cycle:
- Bus events (START, STOP, rising SCL, falling SCL) are mutually exclusive.
- SDA is released in the ignoring state, after a STOP and after a timeout.
- The acknowledge is driven while its state is held.
- The pointer steps after every write strobe.
- The timeout counter stays within its bound and freezes while the oscillator is off.

Only the bench's scenarios can show:
- The address decode for matching and foreign addresses.
- That pointer loading ignores the upper bits.
- Wrap-around in both directions.
- MSB-first read data.
- That a NACK stops the transmitter.
- That a fresh START is served after a timeout.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_SKIP
   } i2cr_state_e;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_s,
   output logic sda_s,
   output logic start_p,
   output logic stop_p,
   output logic rise_p,
   output logic fall_p
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
         scl_q    <= scl_s;
         sda_q    <= sda_s;
      end
   end

   assign scl_s   = scl_pipe[STAGES-1];
   assign sda_s   = sda_pipe[STAGES-1];
   assign start_p = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p  = scl_s & scl_q & ~sda_q & sda_s;
   assign rise_p  = scl_s & ~scl_q;
   assign fall_p  = ~scl_s & scl_q;

   // R8
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_p, stop_p, rise_p, fall_p}));
endmodule

// File: rtl/i2cr_timeout.sv
module i2cr_timeout #(
   parameter int LIMIT = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic osc_en,
   output logic tmo_p
);
   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("i2cr_timeout: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (scl_s) begin
         cnt <= '0;
      end else if (osc_en && (cnt != CW'(LIMIT))) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tmo_p = !scl_s && osc_en && (cnt == CW'(LIMIT - 1));

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT));
   // R10
   fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_p |=> !tmo_p);
   // R11
   osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !scl_s) |=> $stable(cnt));
endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
   import i2cr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h68,
   parameter int         AW       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_p,
   input  logic              stop_p,
   input  logic              rise_p,
   input  logic              fall_p,
   input  logic              sda_s,
   input  logic              tmo_p,
   output logic              sda_oe,
   output logic [AW-1:0]     reg_addr,
   output logic              reg_we,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_rd,
   input  logic [BYTE_W-1:0] reg_rdata
);
   i2cr_state_e       st;
   logic [3:0]        bcnt;
   logic [BYTE_W-1:0] shreg;
   logic [AW-1:0]     ptr;
   logic              first_q;
   logic              rw_q;
   logic              nack_q;
   logic              oe_q;
   logic              we_q;
   logic [BYTE_W-1:0] wd_q;
   logic              rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bcnt    <= '0;
         shreg   <= '0;
         ptr     <= '0;
         first_q <= 1'b0;
         rw_q    <= 1'b0;
         nack_q  <= 1'b0;
         oe_q    <= 1'b0;
         we_q    <= 1'b0;
         wd_q    <= '0;
         rd_q    <= 1'b0;
      end else begin
         we_q <= 1'b0;
         rd_q <= 1'b0;
         if (we_q) ptr <= ptr + 1'b1;
         if (tmo_p || stop_p) begin
            st   <= ST_IDLE;
            oe_q <= 1'b0;
         end else if (start_p) begin
            st   <= ST_ADDR;
            bcnt <= '0;
            oe_q <= 1'b0;
         end else begin
            case (st)
               ST_IDLE, ST_SKIP: begin
               end
               ST_ADDR: begin
                  if (rise_p) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     bcnt  <= bcnt + 4'd1;
                  end else if (fall_p && bcnt == 4'd8) begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        st   <= ST_AACK;
                        oe_q <= 1'b1;
                        rw_q <= shreg[0];
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (fall_p) begin
                     bcnt <= '0;
                     if (rw_q) begin
                        st    <= ST_RDAT;
                        shreg <= reg_rdata;
                        oe_q  <= ~reg_rdata[7];
                        rd_q  <= 1'b1;
                     end else begin
                        st      <= ST_WDAT;
                        oe_q    <= 1'b0;
                        first_q <= 1'b1;
                     end
                  end
               end
               ST_WDAT: begin
                  if (rise_p) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     bcnt  <= bcnt + 4'd1;
                  end else if (fall_p && bcnt == 4'd8) begin
                     st   <= ST_WACK;
                     oe_q <= 1'b1;
                     if (first_q) begin
                        ptr     <= shreg[AW-1:0];
                        first_q <= 1'b0;
                     end else begin
                        we_q <= 1'b1;
                        wd_q <= shreg;
                     end
                  end
               end
               ST_WACK: begin
                  if (fall_p) begin
                     st   <= ST_WDAT;
                     oe_q <= 1'b0;
                     bcnt <= '0;
                  end
               end
               ST_RDAT: begin
                  if (rise_p) begin
                     bcnt <= bcnt + 4'd1;
                  end else if (fall_p) begin
                     if (bcnt == 4'd8) begin
                        st   <= ST_RACK;
                        oe_q <= 1'b0;
                        ptr  <= ptr + 1'b1;
                     end else begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        oe_q  <= ~shreg[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (rise_p) begin
                     nack_q <= sda_s;
                  end else if (fall_p) begin
                     if (nack_q) begin
                        st   <= ST_SKIP;
                        oe_q <= 1'b0;
                     end else begin
                        st    <= ST_RDAT;
                        bcnt  <= '0;
                        shreg <= reg_rdata;
                        oe_q  <= ~reg_rdata[7];
                        rd_q  <= 1'b1;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe    = oe_q;
   assign reg_addr  = ptr;
   assign reg_we    = we_q;
   assign reg_wdata = wd_q;
   assign reg_rd    = rd_q;

   // R3
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> (!sda_oe && !reg_we && !reg_rd));
   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_oe);
   // R10
   tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_p |=> !sda_oe);
   // R2
   ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AACK || st == ST_WACK) |-> sda_oe);
   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> reg_addr == AW'($past(reg_addr) + 1'b1));
   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_rd));
endmodule

// File: rtl/i2cr_target.sv
module i2cr_target
   import i2cr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         REG_AW      = 4,
   parameter int         SYNC_STAGES = 2,
   parameter int         TIMEOUT_CYC = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              osc_en,
   output logic              sda_oe,
   output logic [REG_AW-1:0] reg_addr,
   output logic              reg_we,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_rd,
   input  logic [BYTE_W-1:0] reg_rdata
);
   generate
      if (REG_AW < 1 || REG_AW > BYTE_W) begin : g_bad_aw
         $error("i2cr_target: REG_AW must lie in 1..8");
      end
   endgenerate

   logic scl_s, sda_s, start_p, stop_p, rise_p, fall_p, tmo_p;

   i2cr_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p),
      .rise_p(rise_p), .fall_p(fall_p)
   );

   i2cr_timeout #(.LIMIT(TIMEOUT_CYC)) tmo_i (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .osc_en(osc_en), .tmo_p(tmo_p)
   );

   i2cr_engine #(.DEV_ADDR(DEV_ADDR), .AW(REG_AW)) eng_i (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
      .rise_p(rise_p), .fall_p(fall_p), .sda_s(sda_s), .tmo_p(tmo_p),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
   );
endmodule

// File: tb/i2cr_target_tb.sv
module i2cr_target_tb_top;
   localparam int TO = 300;
   localparam int Q  = 25;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       osc_en = 1'b1;
   logic       sda_oe;
   logic [3:0] reg_addr;
   logic       reg_we;
   logic [7:0] reg_wdata;
   logic       reg_rd;
   logic [7:0] reg_rdata;
   logic       sda_line;

   int total = 0;
   int bad = 0;
   bit quiet = 1'b0;
   logic [7:0]  regs [16];
   logic [7:0]  mm [16];
   int          m_ptr = 0;
   logic [11:0] exp_wq [$];

   always #4 clk = ~clk;

   assign sda_line  = m_sda & ~sda_oe;
   assign reg_rdata = regs[reg_addr];

   i2cr_target #(.TIMEOUT_CYC(TO)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .osc_en(osc_en), .sda_oe(sda_oe), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata)
   );

   always @(posedge clk) if (reg_we) regs[reg_addr] <= reg_wdata;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // every-clock comparison against the behavioural model
   always @(negedge clk) begin
      if (rst_n) begin
         if (quiet) chk(!sda_oe, "R3/R7 quiet window", int'(sda_oe), 0);
         if (reg_we) begin
            if (exp_wq.size() == 0) begin
               chk(1'b0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
            end else begin
               logic [11:0] e;
               e = exp_wq.pop_front();
               chk({reg_addr, reg_wdata} == e, "R5/R6 write", {reg_addr, reg_wdata}, e);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit hush, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; tick(Q);
         if (i == 7) quiet = 1'b1;
         m_scl = 1'b1; tick(2 * Q);
         m_scl = 1'b0;
         if (i == 0) quiet = hush;
         tick(Q);
      end
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      @(negedge clk); ack = ~sda_line;
      tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit nack);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         m_scl = 1'b1; tick(Q);
         @(negedge clk); b[i] = sda_line;
         tick(Q);
         m_scl = 1'b0; tick(Q);
      end
      m_sda = nack; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic rd_bytes(input int n, input string tag);
      logic [7:0] b;
      for (int k = 0; k < n; k++) begin
         recv_byte(b, k == n - 1);
         chk(b == mm[m_ptr], tag, b, mm[m_ptr]);
         m_ptr = (m_ptr + 1) % 16;
      end
   endtask

   task automatic wr_xfer(input logic [7:0] p, input int n, input int seed);
      bit ack;
      bus_start();
      send_byte(8'hD0, 1'b0, ack); chk(ack, "R2 write address ack", ack, 1);
      send_byte(p, 1'b0, ack);     chk(ack, "R4 pointer byte ack", ack, 1);
      m_ptr = int'(p[3:0]);
      for (int k = 0; k < n; k++) begin
         logic [7:0] d;
         d = 8'((seed + k * 37) & 8'h7F);
         exp_wq.push_back({4'(m_ptr), d});
         mm[m_ptr] = d;
         send_byte(d, 1'b0, ack); chk(ack, "R5 data ack", ack, 1);
         m_ptr = (m_ptr + 1) % 16;
      end
      quiet = 1'b0;
      bus_stop();
   endtask

   task automatic rd_xfer(input int n, input string tag);
      bit ack;
      bus_start();
      send_byte(8'hD1, 1'b0, ack); chk(ack, "R2 read address ack", ack, 1);
      quiet = 1'b0;
      rd_bytes(n, tag);
      bus_stop();
   endtask

   task automatic ptr_rs_read(input logic [7:0] p, input int n, input string tag);
      bit ack;
      bus_start();
      send_byte(8'hD0, 1'b0, ack); chk(ack, "R2 write address ack", ack, 1);
      send_byte(p, 1'b0, ack);     chk(ack, "R4 pointer ack", ack, 1);
      m_ptr = int'(p[3:0]);
      quiet = 1'b0;
      bus_rstart();
      send_byte(8'hD1, 1'b0, ack); chk(ack, "R8 address after repeated START", ack, 1);
      quiet = 1'b0;
      rd_bytes(n, tag);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit ack;
      logic [7:0] b;
      for (int i = 0; i < 16; i++) begin regs[i] = 8'h00; mm[i] = 8'h00; end
      tick(5);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(!sda_oe && !reg_we && !reg_rd, "R1 reset outputs", {sda_oe, reg_we, reg_rd}, 0);
      tick(10);

      // R4 R5: burst write from pointer 3, then R8 R7 read back via repeated START
      wr_xfer(8'h03, 4, 8'h5A);
      ptr_rs_read(8'h03, 4, "R7 read data");
      // R7: a fresh read continues at the current pointer
      wr_xfer(8'h08, 3, 8'h21);
      ptr_rs_read(8'h08, 1, "R8 read data");
      rd_xfer(2, "R7 current pointer read");

      // R6: wrap in write and read
      wr_xfer(8'h0E, 4, 8'h13);
      ptr_rs_read(8'h0E, 4, "R6 wrapped read");

      // R4: upper bits of the pointer byte are ignored
      ptr_rs_read(8'hF5, 1, "R4 masked pointer");

      // R3: foreign address is ignored until START
      begin
         int keep;
         keep = m_ptr;
         bus_start();
         send_byte(8'hA0, 1'b1, ack); chk(!ack, "R3 foreign address no ack", ack, 0);
         send_byte(8'h05, 1'b1, ack); chk(!ack, "R3 ignored byte", ack, 0);
         send_byte(8'hD0, 1'b1, ack); chk(!ack, "R3 lookalike byte ignored", ack, 0);
         quiet = 1'b0;
         bus_stop();
         m_ptr = keep;
         rd_xfer(1, "R3 pointer and data unchanged");
      end

      // R7: NACK ends the read, further clocks see no drive
      bus_start();
      send_byte(8'hD1, 1'b0, ack); chk(ack, "R2 read address ack", ack, 1);
      quiet = 1'b0;
      rd_bytes(1, "R7 single read");
      quiet = 1'b1;
      recv_byte(b, 1'b1);
      chk(b == 8'hFF, "R7 released after NACK", b, 8'hFF);
      quiet = 1'b0;
      bus_stop();
      rd_xfer(1, "R7 pointer stepped once");

      // R9: STOP after pointer byte and STOP inside a data byte
      bus_start();
      send_byte(8'hD0, 1'b0, ack);
      send_byte(8'h06, 1'b0, ack);
      m_ptr = 6;
      quiet = 1'b0;
      for (int i = 0; i < 3; i++) begin
         m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0; tick(Q);
      end
      bus_stop();
      @(negedge clk);
      chk(!sda_oe, "R9 released after STOP", sda_oe, 0);
      chk(exp_wq.size() == 0, "R9 partial byte not written", exp_wq.size(), 0);
      rd_xfer(1, "R9 data unchanged");

      // R11 then R10: stuck SCL while the target drives a zero bit
      osc_en = 1'b0;
      bus_start();
      send_byte(8'hD1, 1'b0, ack); chk(ack, "R2 read address ack", ack, 1);
      quiet = 1'b0;
      tick(TO + 100);
      @(negedge clk);
      chk(sda_oe, "R11 no timeout with oscillator off", sda_oe, 1);
      osc_en = 1'b1;
      tick(TO - 60);
      @(negedge clk);
      chk(sda_oe, "R10 still driven before limit", sda_oe, 1);
      tick(120);
      @(negedge clk);
      chk(!sda_oe, "R10 released after timeout", sda_oe, 0);
      m_scl = 1'b1; tick(Q);
      rd_xfer(2, "R10 fresh START served");

      chk(exp_wq.size() == 0, "R5 all writes seen", exp_wq.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule